// File: doc/BRIEF.md
# ADC Window Alarm Filter

This block watches the stream of 12-bit conversion results coming out of a multi-channel ADC. It compares each result with a low and a high limit that belong to the channel it was taken on, and keeps one alarm flag per channel. A short out-of-range excursion does not raise the alarm. The alarm is raised only after a programmed run of consecutive results outside the window. Once raised, it is released only when a result falls inside a window that has been narrowed by a shared hysteresis value. The run counter, the hysteresis narrowing and the threshold arithmetic are the whole of its function.

Each channel's limits are built from two 8-bit configuration fields. One channel can instead follow a tracking window centred on the code the ADC should read back for the present DAC code. This lets a loop-back measurement of the DAC output be checked while the DAC code changes. The ADC, the channel sequencer, interrupt routing and register access all sit outside the block.

Top module: `adc_window_alarm`

## Requirements
- R1: While `rst_n` is low at a clock edge, every alarm flag and every consecutive-failure counter is cleared, so `alarm` reads all zeros after reset.
- R2: A result on an enabled channel is a failure only when it is strictly below the low limit or strictly above the high limit; a result equal to either limit passes.
- R3: A channel's alarm rises on its failure number `fault_limit`+1 in an unbroken run (a limit of 0 raises it on the first failure, a limit of 2 on the third).
- R4: Failures above the high limit and below the low limit add to the same run, in any mix.
- R5: A passing result clears that channel's run counter; the counter saturates at its maximum instead of wrapping.
- R6: An active alarm is released by the first result that lies between low limit plus `hyst` and high limit minus `hyst`, inclusive; a result that passes the plain window but lies outside the narrowed one leaves the alarm set.
- R7: For a fixed channel c, the low limit is {`lo_cfg`[8c+7:8c], 4'h0} and the high limit is {`hi_cfg`[8c+7:8c], 4'hF}.
- R8: A channel whose low field is 8'h00 and high field is 8'hFF is disabled: none of its results counts as a failure, and any of its results clears its counter and its alarm.
- R9: On the tracking channel (index NUM_CH-1 by default), the expected code E is floor(T*113/128)+492 when `dac_range` is 0 and floor(T*82/128)+655 when it is 1, with T the top 12 bits of `dac_code`; its limits are E-64 and E+64. Its configuration fields only select enabled or disabled as in R8.
- R10: All limit arithmetic (tracking bounds and hysteresis narrowing) saturates at 0x000 and 0xFFF and never wraps.
- R11: A result is evaluated only in a cycle where `conv_valid` is high, and only for the channel `conv_ch` selects; the alarm flag changes at the clock edge that samples the strobe and is held in every other cycle.
- R12: `fault_limit` and `hyst` are shared by all channels, while each channel keeps its own counter and alarm, unaffected by results on other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | Conversion result strobe, one cycle per result |
| conv_ch | input | CH_W | Channel the result belongs to |
| conv_data | input | 12 | Conversion result |
| lo_cfg | input | 8*NUM_CH | Upper 8 bits of each channel's low limit, channel c in bits 8c+7:8c |
| hi_cfg | input | 8*NUM_CH | Upper 8 bits of each channel's high limit, channel c in bits 8c+7:8c |
| fault_limit | input | CNT_W | Tolerated consecutive failures, shared |
| hyst | input | HYST_W | Release hysteresis in LSBs, shared |
| dac_code | input | DAC_W | Present DAC code for the tracking channel |
| dac_range | input | 1 | DAC range select for the tracking equation |
| alarm | output | NUM_CH | Registered per-channel alarm flags |

## Verification
The stimulus covers runs of failures that stay on one side, runs that alternate between sides, and runs broken by a single pass. Together these separate a correct run counter from one that resets on a change of side or ignores passes. Results placed exactly on each limit, and one LSB past it, separate strict from inclusive compares. Results between the plain limit and the hysteresis-narrowed limit show whether release uses the narrowed window. A threshold near zero with a large hysteresis, and a DAC code at full scale, show whether the arithmetic saturates or wraps. The tracking channel is driven at two DAC codes and both ranges to tell the two equations apart.

// File: rtl/awa_pkg.sv
// Package: shared constants and the window type for the ADC window alarm.
// Assumes 12-bit conversion results and 8-bit threshold configuration fields.
package awa_pkg;
    localparam int DATA_W = 12;
    localparam int CFG_W  = 8;
    localparam int NIB_W  = DATA_W - CFG_W;
    localparam logic [DATA_W-1:0] CODE_MAX = '1;

    // One channel's limits: plain window for detection, narrowed one for release
    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] rel_lo;
        logic [DATA_W-1:0] rel_hi;
    } win_t;
endpackage

// File: rtl/awa_track_calc.sv
// Module: computes the tracking window from the DAC code and range select.
// Expected code E = floor(T*gain/128)+offset, T = top 12 bits of the DAC code.
// The window is E-HALF_W .. E+HALF_W, each bound saturated to 0x000..0xFFF.
// Assumes DAC_W >= 12.
module awa_track_calc
    import awa_pkg::*;
#(
    parameter int DAC_W  = 16,
    parameter int GAIN0  = 113,
    parameter int OFFS0  = 492,
    parameter int GAIN1  = 82,
    parameter int OFFS1  = 655,
    parameter int HALF_W = 64
) (
    input  logic [DAC_W-1:0]  dac_code,
    input  logic              dac_range,
    output logic [DATA_W-1:0] trk_lo,
    output logic [DATA_W-1:0] trk_hi
);
    localparam int PROD_W = DATA_W + 8;
    localparam int EXP_W  = DATA_W + 3;

    logic [DATA_W-1:0] top;
    logic [PROD_W-1:0] prod0, prod1;
    logic [EXP_W-1:0]  exp0, exp1, exp_sel;
    logic [EXP_W-1:0]  lo_wide, hi_wide;

    assign top = dac_code[DAC_W-1 -: DATA_W];

    // Expected code for both ranges, then select
    always_comb begin
        prod0   = PROD_W'(top) * PROD_W'(GAIN0);
        prod1   = PROD_W'(top) * PROD_W'(GAIN1);
        exp0    = EXP_W'(prod0 >> 7) + EXP_W'(OFFS0);
        exp1    = EXP_W'(prod1 >> 7) + EXP_W'(OFFS1);
        exp_sel = dac_range ? exp1 : exp0;
    end

    // Window bounds with saturation at both ends of the code range
    always_comb begin
        lo_wide = (exp_sel >= EXP_W'(HALF_W)) ? exp_sel - EXP_W'(HALF_W) : '0;
        hi_wide = exp_sel + EXP_W'(HALF_W);
        trk_lo  = (lo_wide > EXP_W'(CODE_MAX)) ? CODE_MAX : lo_wide[DATA_W-1:0];
        trk_hi  = (hi_wide > EXP_W'(CODE_MAX)) ? CODE_MAX : hi_wide[DATA_W-1:0];
    end

    // Bounds are ordered and never further apart than the full window
    always_comb begin
        // R10
        trk_order_chk: assert (trk_hi >= trk_lo && (trk_hi - trk_lo) <= DATA_W'(2*HALF_W));
    end
endmodule

// File: rtl/awa_window.sv
// Module: builds one channel's detection and release limits.
// A fixed channel widens its 8-bit fields with a 0x0 / 0xF nibble; the tracking
// variant takes its limits from awa_track_calc. Hysteresis narrows the release
// window with saturating arithmetic. Fields 0x00/0xFF mark the channel disabled.
module awa_window
    import awa_pkg::*;
#(
    parameter int HYST_W   = 8,
    parameter bit IS_TRACK = 1'b0
) (
    input  logic [CFG_W-1:0]  lo_field,
    input  logic [CFG_W-1:0]  hi_field,
    input  logic [DATA_W-1:0] trk_lo,
    input  logic [DATA_W-1:0] trk_hi,
    input  logic [HYST_W-1:0] hyst,
    output win_t              win
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] base_lo, base_hi;
    logic [SUM_W-1:0]  lo_plus;
    logic [DATA_W-1:0] hyst_ext;

    // Pick the plain limits by variant
    generate
        if (IS_TRACK) begin : g_track
            assign base_lo = trk_lo;
            assign base_hi = trk_hi;
        end else begin : g_fixed
            assign base_lo = {lo_field, {NIB_W{1'b0}}};
            assign base_hi = {hi_field, {NIB_W{1'b1}}};
        end
    endgenerate

    // Enable decode and saturating hysteresis narrowing
    always_comb begin
        hyst_ext   = DATA_W'(hyst);
        lo_plus    = SUM_W'(base_lo) + SUM_W'(hyst_ext);
        win.en     = !(lo_field == '0 && hi_field == '1);
        win.lo     = base_lo;
        win.hi     = base_hi;
        win.rel_lo = lo_plus[DATA_W] ? CODE_MAX : lo_plus[DATA_W-1:0];
        win.rel_hi = (base_hi >= hyst_ext) ? base_hi - hyst_ext : '0;
    end

    // Release window never extends past the detection window
    always_comb begin
        // R10
        rel_inside_chk: assert (win.rel_lo >= win.lo && win.rel_hi <= win.hi);
    end
endmodule

// File: rtl/awa_chan.sv
// Module: per-channel run counter and alarm state.
// On a strobe for this channel: a failure extends the run and raises the alarm
// once the run exceeds the shared limit; a pass clears the run; while the alarm
// is set, a result inside the narrowed window releases it. State holds otherwise.
module awa_chan
    import awa_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    input  win_t              win,
    input  logic [CNT_W-1:0]  fault_limit,
    output logic              alarm
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fail, in_rel;
    logic [CNT_W-1:0] run_q;
    logic             alarm_q;

    // Classify the presented result against both windows
    always_comb begin
        fail   = win.en && (data < win.lo || data > win.hi);
        in_rel = !win.en || (data >= win.rel_lo && data <= win.rel_hi);
    end

    // Run counter and alarm register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            alarm_q <= 1'b0;
        end else if (hit) begin
            if (fail) begin
                run_q <= (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
                if (!alarm_q && run_q >= fault_limit) alarm_q <= 1'b1;
            end else begin
                run_q <= '0;
            end
            if (alarm_q && in_rel) begin
                alarm_q <= 1'b0;
                run_q   <= '0;
            end
        end
    end

    assign alarm = alarm_q;

    // R3
    rise_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(hit && fail));
    // R6
    fall_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_q) |-> $past(hit && in_rel));
    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(alarm_q) && $stable(run_q));
    // R5
    pass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !fail) |=> (run_q == '0));
endmodule

// File: rtl/adc_window_alarm.sv
// Module: ADC window alarm filter, top level.
// Routes each strobed result to its channel, builds per-channel windows (the
// last channel, by default, follows the DAC tracking window) and collects the
// registered alarm flags. Assumes NUM_CH >= 2 and TRACK_CH < NUM_CH.
module adc_window_alarm
    import awa_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int TRACK_CH = NUM_CH - 1,
    parameter int CNT_W    = 4,
    parameter int HYST_W   = 8,
    parameter int DAC_W    = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_valid,
    input  logic [CH_W-1:0]         conv_ch,
    input  logic [11:0]             conv_data,
    input  logic [8*NUM_CH-1:0]     lo_cfg,
    input  logic [8*NUM_CH-1:0]     hi_cfg,
    input  logic [CNT_W-1:0]        fault_limit,
    input  logic [HYST_W-1:0]       hyst,
    input  logic [DAC_W-1:0]        dac_code,
    input  logic                    dac_range,
    output logic [NUM_CH-1:0]       alarm
);
    logic [DATA_W-1:0] trk_lo, trk_hi;

    // Shared tracking window computation
    awa_track_calc #(.DAC_W(DAC_W)) u_track (
        .dac_code (dac_code),
        .dac_range(dac_range),
        .trk_lo   (trk_lo),
        .trk_hi   (trk_hi)
    );

    // One window builder and one state slice per channel
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            win_t win;
            logic hit;

            assign hit = conv_valid && (conv_ch == CH_W'(c));

            awa_window #(.HYST_W(HYST_W), .IS_TRACK(c == TRACK_CH)) u_win (
                .lo_field(lo_cfg[CFG_W*c +: CFG_W]),
                .hi_field(hi_cfg[CFG_W*c +: CFG_W]),
                .trk_lo  (trk_lo),
                .trk_hi  (trk_hi),
                .hyst    (hyst),
                .win     (win)
            );

            awa_chan #(.CNT_W(CNT_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .hit        (hit),
                .data       (conv_data),
                .win        (win),
                .fault_limit(fault_limit),
                .alarm      (alarm[c])
            );
        end
    endgenerate

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (alarm == '0));
    // R12
    one_channel_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alarm ^ $past(alarm)) <= 1);
endmodule

// File: tb/tb_adc_window_alarm.sv
// Scoreboard bench: the driver applies one result, updates a reference model
// and queues the expected alarm vector; the monitor compares it one clock later.
module tb_adc_window_alarm;
    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;
    localparam int TRK    = 3;

    typedef struct {
        logic [NUM_CH-1:0] exp;
        string             tag;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                conv_valid = 1'b0;
    logic [CH_W-1:0]     conv_ch = '0;
    logic [11:0]         conv_data = '0;
    logic [8*NUM_CH-1:0] lo_cfg = '0;
    logic [8*NUM_CH-1:0] hi_cfg = '1;
    logic [3:0]          fault_limit = '0;
    logic [7:0]          hyst = '0;
    logic [15:0]         dac_code = '0;
    logic                dac_range = 1'b0;
    logic [NUM_CH-1:0]   alarm;

    int n_chk = 0, n_fail = 0;
    int m_run [NUM_CH];
    bit m_alm [NUM_CH];
    item_t sb_q[$];
    logic v_d = 1'b0;

    always #10 clk = ~clk;

    adc_window_alarm dut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
        .conv_data(conv_data), .lo_cfg(lo_cfg), .hi_cfg(hi_cfg),
        .fault_limit(fault_limit), .hyst(hyst), .dac_code(dac_code),
        .dac_range(dac_range), .alarm(alarm)
    );

    function automatic logic [NUM_CH-1:0] model_vec();
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++) v[i] = m_alm[i];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NUM_CH-1:0] act, input logic [NUM_CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm=%b expected=%b", tag, act, exp);
        end
    endtask

    // Reference model step for one result on channel ch
    task automatic model(input int ch, input int d);
        int lo, hi, rlo, rhi, t, e, lf, hf;
        bit en, fl, inr;
        lf = lo_cfg[8*ch +: 8];
        hf = hi_cfg[8*ch +: 8];
        en = !(lf == 0 && hf == 255);
        if (ch == TRK) begin
            t  = dac_code[15:4];
            e  = dac_range ? (t * 82) / 128 + 655 : (t * 113) / 128 + 492;
            lo = e - 64; hi = e + 64;
            if (lo < 0) lo = 0;
            if (lo > 4095) lo = 4095;
            if (hi > 4095) hi = 4095;
        end else begin
            lo = lf * 16; hi = hf * 16 + 15;
        end
        rlo = lo + hyst; if (rlo > 4095) rlo = 4095;
        rhi = hi - hyst; if (rhi < 0) rhi = 0;
        fl  = en && (d < lo || d > hi);
        inr = !en || (d >= rlo && d <= rhi);
        if (fl) begin
            if (!m_alm[ch] && m_run[ch] >= fault_limit) m_alm[ch] = 1'b1;
            else if (m_alm[ch] == 1'b0) ; // run below limit
            if (m_run[ch] < 15) m_run[ch]++;
        end else begin
            m_run[ch] = 0;
        end
        if (m_alm[ch] && inr && !fl) begin
            m_alm[ch] = 1'b0; m_run[ch] = 0;
        end
    endtask

    // Driver: one strobed result, expected vector queued for the monitor
    task automatic conv(input int ch, input int d, input string tag);
        item_t it;
        @(negedge clk);
        conv_ch = CH_W'(ch); conv_data = 12'(d); conv_valid = 1'b1;
        model(ch, d);
        it.exp = model_vec(); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    always @(posedge clk) v_d <= conv_valid;

    // Monitor: compare the alarm vector one clock after each strobe
    always @(negedge clk) begin
        if (v_d && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, alarm, it.exp);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: alarm=%b expected=done", alarm);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin m_run[i] = 0; m_alm[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check("R1 reset", alarm, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", alarm, '0);

        // Channel 0: low 0x200, high 0x80F (R7), limit 2, hyst 0x10
        lo_cfg[7:0] = 8'h20; hi_cfg[7:0] = 8'h80;
        fault_limit = 4'd2; hyst = 8'h10;
        conv(0, 12'h200, "R2 equal low passes");
        conv(0, 12'h80F, "R2 R7 equal high passes");
        conv(0, 12'h1FF, "R2 one below low fails");
        conv(0, 12'h810, "R4 alternating side");
        conv(0, 12'h100, "R3 R4 third failure raises");
        conv(0, 12'h801, "R6 inside plain, outside narrowed");
        conv(0, 12'h20F, "R6 low side not narrowed enough");
        conv(0, 12'h7FF, "R6 release at narrowed high");
        // R5: a pass breaks the run
        conv(0, 12'h000, "R5 fail 1");
        conv(0, 12'hFFF, "R5 fail 2");
        conv(0, 12'h400, "R5 pass clears run");
        conv(0, 12'h000, "R5 fail after clear");
        conv(0, 12'h000, "R5 second fail");
        conv(0, 12'h000, "R3 third fail raises");

        // R8: channel 1 disabled by default pattern; extremes never alarm
        conv(1, 12'h000, "R8 disabled low extreme");
        conv(1, 12'hFFF, "R8 disabled high extreme");

        // R10 R12: channel 2 low 0x000 high 0x05F with hyst 0xFF, limit 0
        fault_limit = 4'd0; hyst = 8'hFF;
        lo_cfg[23:16] = 8'h00; hi_cfg[23:16] = 8'h05;
        conv(2, 12'h100, "R3 R12 limit 0 raises on first");
        conv(2, 12'h010, "R10 saturated narrowing keeps alarm");
        lo_cfg[23:16] = 8'h00; hi_cfg[23:16] = 8'hFF;
        conv(2, 12'h800, "R8 disabling clears alarm");

        // R9: tracking channel, enabled with non-disable fields
        hyst = 8'h00;
        lo_cfg[31:24] = 8'h01; hi_cfg[31:24] = 8'h01;
        dac_code = 16'h8000; dac_range = 1'b0;
        conv(3, 2364, "R9 range0 at high bound passes");
        conv(3, 2236, "R9 range0 at low bound passes");
        conv(3, 2365, "R9 range0 above bound raises");
        conv(3, 2300, "R9 range0 release at centre");
        dac_range = 1'b1;
        conv(3, 2300, "R9 range1 window differs");
        conv(3, 1967, "R9 range1 release at centre");
        dac_code = 16'hFFF0; dac_range = 1'b0;
        conv(3, 4095, "R10 full-scale tracking bound saturates");
        conv(3, 4042, "R9 R10 below saturated window raises");

        // R11: idle cycles with changed inputs must not move the alarm
        @(negedge clk);
        conv_ch = 2'd3; conv_data = 12'd4095;
        repeat (4) @(negedge clk);
        check("R11 no strobe holds alarm", alarm, model_vec());
        conv_ch = 2'd0; conv_data = 12'h000; fault_limit = 4'd0; hyst = 8'h00;
        repeat (2) @(negedge clk);
        check("R11 R12 ch0 untouched without strobe", alarm, model_vec());

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11 scoreboard: pending=%0d expected=0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule